// File: doc/BRIEF.md
# Seven-bit GPIO port with pull-up control

This block is a general-purpose I/O port of seven pins on a simple synchronous register bus. The bus has an address, a write strobe, write data and a combinational read-data return. Three registers control the port. The data latch holds the value to drive, the direction register picks input or output per pin, and the pull-up enable register asks for a weak pull-up per pin. For every pin the block drives an output value, an output enable and a pull-up request toward the pad, and it takes back the level sampled at the pad.

The data-register read is mixed bit by bit. Bits configured as outputs return the stored latch. Bits configured as inputs return the pad level after a two-stage synchronizer. The pull-up request is gated with the direction, so a pin that becomes an output loses its pull-up at once. Firmware can load the latch while a pin is still an input and then flip the direction bit. The pin then starts driving the loaded value on that same cycle.

Top module: `pio_bank`

## Requirements
- R1: After reset, the data, direction and pull-up enable registers are all zero. Every pin_oe, pin_pu and pin_out bit is 0.
- R2: A write to offset 0x02 updates the data latch whatever the direction bits hold, and pin_out always presents the latch.
- R3: The direction register at offset 0x06 reads back what was last written. A pin_oe bit equals its direction bit (1 = output, 0 = high impedance).
- R4: A read of offset 0x02 returns the latch for bits whose direction bit is 1, and the synchronized pin level for bits whose direction bit is 0.
- R5: The pull-up enable register at offset 0x0C reads back what was last written.
- R6: pin_pu of a bit is 1 only when its pull-up enable bit is 1 and its direction bit is 0. It drops in the same cycle the direction bit becomes 1.
- R7: A data value written while a pin is an input is driven unchanged on the first cycle pin_oe is 1. pin_out does not change in any cycle in which pin_oe changes.
- R8: A pin-level change is not yet visible in a data read one clock edge later. It is visible after the second edge (two-flop synchronizer).
- R9: Bit 7 of every register reads as 0, and a 1 written to bit 7 has no effect.
- R10: Reads of any offset other than 0x02, 0x06 and 0x0C return 0. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |
| pin_in | input | 7 | Level sampled at the pads |
| pin_out | output | 7 | Value to drive on each pad |
| pin_oe | output | 7 | Per-pin output enable |
| pin_pu | output | 7 | Per-pin weak pull-up request |

## Verification
The bench builds the block with its default parameters: seven pins, an eight-bit bus, offsets 0x02, 0x06 and 0x0C, and two synchronizer stages. With two stages, the one-edge and two-edge windows of the pin read path can be checked exactly. The pad model resolves the level from the block's own drive, an optional external driver and the weak pull-up. This lets a mixed-direction read, the pull-up gating and the drive when a pin turns to output each show at the ports.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int PIO_PINS = 7;
    localparam int BUS_W    = 8;
    localparam int ADDR_W   = 8;

    typedef logic [PIO_PINS-1:0] pins_t;

    typedef struct packed {
        pins_t dat;
        pins_t dir;
        pins_t pue;
    } pio_regs_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DAT  = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_PUE  = 2'd3
    } pio_sel_t;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stg_d[s] = async_in;
            end else begin : g_next
                always_comb stg_d[s] = stg_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_d[s];
            end
        end
    endgenerate

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pio_sel_t  sel,
    input  logic      we,
    input  pins_t     wdata,
    output pio_regs_t regs
);
    pio_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (sel)
                SEL_DAT: r_d.dat = wdata;
                SEL_DIR: r_d.dir = wdata;
                SEL_PUE: r_d.pue = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign regs = r_q;
endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
    import pio_pkg::*;
(
    input  pio_sel_t          sel,
    input  pio_regs_t         regs,
    input  pins_t             pin_sync,
    output logic [BUS_W-1:0]  rdata
);
    localparam int PAD_W = BUS_W - PIO_PINS;
    pins_t val;

    always_comb begin
        case (sel)
            SEL_DAT: val = (regs.dat & regs.dir) | (pin_sync & ~regs.dir);
            SEL_DIR: val = regs.dir;
            SEL_PUE: val = regs.pue;
            default: val = '0;
        endcase
        rdata = {{PAD_W{1'b0}}, val};
    end
endmodule

// File: rtl/pio_bank.sv
module pio_bank
    import pio_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DAT_OFF     = 8'h02,
    parameter logic [ADDR_W-1:0] DIR_OFF     = 8'h06,
    parameter logic [ADDR_W-1:0] PUE_OFF     = 8'h0C,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [PIO_PINS-1:0] pin_in,
    output logic [PIO_PINS-1:0] pin_out,
    output logic [PIO_PINS-1:0] pin_oe,
    output logic [PIO_PINS-1:0] pin_pu
);
    pio_sel_t  sel;
    pio_regs_t regs;
    pins_t     pin_sync;

    always_comb begin
        if      (bus_addr == DAT_OFF) sel = SEL_DAT;
        else if (bus_addr == DIR_OFF) sel = SEL_DIR;
        else if (bus_addr == PUE_OFF) sel = SEL_PUE;
        else                          sel = SEL_NONE;
    end

    pio_sync #(.W(PIO_PINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    pio_regs i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .we    (bus_we),
        .wdata (bus_wdata[PIO_PINS-1:0]),
        .regs  (regs)
    );

    pio_rdmux i_rdmux (
        .sel      (sel),
        .regs     (regs),
        .pin_sync (pin_sync),
        .rdata    (bus_rdata)
    );

    assign pin_out = regs.dat;
    assign pin_oe  = regs.dir;
    assign pin_pu  = regs.pue & ~regs.dir;
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk
    import pio_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DAT_OFF = 8'h02,
    parameter logic [ADDR_W-1:0] DIR_OFF = 8'h06,
    parameter logic [ADDR_W-1:0] PUE_OFF = 8'h0C
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [BUS_W-1:0]    bus_wdata,
    input logic [BUS_W-1:0]    bus_rdata,
    input logic [PIO_PINS-1:0] pin_out,
    input logic [PIO_PINS-1:0] pin_oe,
    input logic [PIO_PINS-1:0] pin_pu
);
    logic unmapped;
    assign unmapped = (bus_addr != DAT_OFF) && (bus_addr != DIR_OFF) && (bus_addr != PUE_OFF);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_pu == '0 && pin_out == '0));

    // R2
    dat_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == DAT_OFF) |=> (pin_out == $past(bus_wdata[PIO_PINS-1:0])));

    // R3
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == DIR_OFF) |=> $stable(pin_oe));

    // R6
    pu_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

    // R7
    no_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_oe) |-> $stable(pin_out));

    // R9
    top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1] == 1'b0);

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> bus_rdata == '0);
endmodule

bind pio_bank pio_bank_chk #(
    .DAT_OFF (DAT_OFF),
    .DIR_OFF (DIR_OFF),
    .PUE_OFF (PUE_OFF)
) i_pio_bank_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_pu    (pin_pu)
);

// File: tb/test_pio_bank.sv
module test_pio_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [6:0] pin_in;
    logic [6:0] pin_out, pin_oe, pin_pu;
    logic [6:0] ext_en = 7'h00;
    logic [6:0] ext_val = 7'h00;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    // Pad model: own drive wins, then external driver, then weak pull-up, else reads low.
    always_comb begin
        for (int i = 0; i < 7; i++)
            pin_in[i] = pin_oe[i] ? pin_out[i] : (ext_en[i] ? ext_val[i] : pin_pu[i]);
    end

    pio_bank i_pio_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        #1;
        chk("R1 oe", {1'b0, pin_oe}, 8'h00);
        chk("R1 pu", {1'b0, pin_pu}, 8'h00);
        chk("R1 out", {1'b0, pin_out}, 8'h00);
        rd(8'h06, v); chk("R1 dir", v, 8'h00);
        rd(8'h0C, v); chk("R1 pue", v, 8'h00);
    endtask

    task automatic t_dir_pue();
        logic [7:0] v;
        wr(8'h06, 8'h2B); rd(8'h06, v); chk("R3 dir readback", v, 8'h2B);
        chk("R3 oe", {1'b0, pin_oe}, 8'h2B);
        wr(8'h0C, 8'h5A); rd(8'h0C, v); chk("R5 pue readback", v, 8'h5A);
        chk("R6 pu gated", {1'b0, pin_pu}, 8'h50);
        wr(8'h06, 8'h00); wr(8'h0C, 8'h00);
    endtask

    task automatic t_data_mixed();
        logic [7:0] v;
        ext_en = 7'h7F; ext_val = 7'h0F;
        wr(8'h02, 8'h33);
        chk("R2 latch while input", {1'b0, pin_out}, 8'h33);
        settle(); rd(8'h02, v); chk("R4 all input", v, 8'h0F);
        wr(8'h06, 8'h70);
        settle(); rd(8'h02, v);
        chk("R4 mixed", v, 8'h3F);
        wr(8'h02, 8'h4C); rd(8'h02, v);
        chk("R2 write under output", v, 8'h4F);
        wr(8'h06, 8'h7F); settle(); rd(8'h02, v);
        chk("R4 all output", v, 8'h4C);
        wr(8'h06, 8'h00); ext_en = 7'h00;
    endtask

    task automatic t_pullup();
        logic [7:0] v;
        wr(8'h0C, 8'h7F);
        settle(); rd(8'h02, v); chk("R6 pulled high", v, 8'h7F);
        @(negedge clk);
        bus_addr = 8'h06; bus_we = 1'b1; bus_wdata = 8'h05;
        @(posedge clk); #1;
        chk("R6 pu drop same cycle", {1'b0, pin_pu}, 8'h7A);
        @(negedge clk); bus_we = 1'b0;
        wr(8'h06, 8'h00); wr(8'h0C, 8'h00);
    endtask

    task automatic t_preload();
        ext_en = 7'h7F; ext_val = 7'h00;
        wr(8'h02, 8'h55);
        @(negedge clk);
        bus_addr = 8'h06; bus_we = 1'b1; bus_wdata = 8'h7F;
        @(posedge clk); #1;
        chk("R7 oe rises", {1'b0, pin_oe}, 8'h7F);
        chk("R7 drives preload", {1'b0, pin_out}, 8'h55);
        @(negedge clk); bus_we = 1'b0;
        wr(8'h06, 8'h00);
    endtask

    task automatic t_sync();
        ext_en = 7'h7F; ext_val = 7'h00;
        @(negedge clk); bus_addr = 8'h02;
        settle();
        ext_val = 7'h6A;
        @(negedge clk); #1;
        chk("R8 one edge", bus_rdata, 8'h00);
        @(negedge clk); #1;
        chk("R8 two edges", bus_rdata, 8'h6A);
        ext_en = 7'h00;
    endtask

    task automatic t_bit7_unmapped();
        logic [7:0] v;
        wr(8'h06, 8'h80); rd(8'h06, v); chk("R9 dir bit7", v, 8'h00);
        wr(8'h0C, 8'hFF); rd(8'h0C, v); chk("R9 pue bit7", v, 8'h7F);
        wr(8'h0C, 8'h00);
        wr(8'h03, 8'h7F); wr(8'h07, 8'h7F); wr(8'h0D, 8'h7F); wr(8'hFF, 8'h7F);
        rd(8'h03, v); chk("R10 unmapped read", v, 8'h00);
        rd(8'hFF, v); chk("R10 unmapped read high", v, 8'h00);
        rd(8'h06, v); chk("R10 dir untouched", v, 8'h00);
        rd(8'h0C, v); chk("R10 pue untouched", v, 8'h00);
        chk("R10 out untouched", {1'b0, pin_out}, 8'h55);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dir_pue();
        t_data_mixed();
        t_pullup();
        t_preload();
        t_sync();
        t_bit7_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule